// File: doc/BRIEF.md
# Dithered Early/Late Spreading Code Generator

This block makes the local spreading code for a direct-sequence receiver that uses two correlator channels instead of three. A 127-chip maximal-length sequence is stepped once every two cycles of a double-rate clock. The one-clock granularity of that clock places an early copy of the code half a chip ahead of the punctual copy and a late copy half a chip behind it.

The punctual code drives the data correlator. A single dithered output drives the second correlator and is time-shared on a schedule of whole sequences: two early ones, then two late ones. Two gate strobes open the early and late sample-and-hold switches. Each strobe is active only during the second sequence of its pair, so the switches never sample while the correlator is still settling after a change of code. One full dither cycle spans 508 chips.

A sequence-start strobe marks chip 0 of every sequence. It gives a fixed phase reference between the code outputs and the gate strobes.

Top module: `dsss_dither_codegen`

## Requirements
- R1: While rst_n is low, and at once when it goes low, the outputs hold these values: code_early=1, code_punct=0, code_late=0, code_dith=1, gate_early=0, gate_late=0, seq_start=1.
- R2: Number the clock edges after reset release t=1,2,… and the state before the first edge t=0. code_early then shows chip x[n mod 127] with n=floor(t/2). The chip values come from x[0..6]=1 and x[k+7]=x[k] xor x[k+1].
- R3: code_punct equals code_early one clock earlier, and code_late equals code_early two clocks earlier. Each reads 0 for the clocks after reset that have no such earlier value.
- R4: With slot k=floor(n/127) mod 4, code_dith equals code_early for k=0 and k=1, and equals code_late for k=2 and k=3.
- R5: gate_early is 1 exactly when k=1, gate_late is 1 exactly when k=3, and the two are never 1 together.
- R6: seq_start is 1 exactly when n mod 127 = 0. It is therefore high for two consecutive clocks, and each gate rises only while it is high.
- R7: Every output repeats with a period of 1016 clocks (508 chips).
- R8: code_early never shows more than six consecutive zero chips, so the sequence generator never reaches its all-zero state.
- R9: Taking rst_n low in the middle of a run restarts the whole schedule from t=0 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double chip-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| code_early | output | 1 | Code half a chip ahead of punctual |
| code_punct | output | 1 | Punctual code |
| code_late | output | 1 | Code half a chip behind punctual |
| code_dith | output | 1 | Time-shared early/late code |
| gate_early | output | 1 | Early sample-and-hold gate |
| gate_late | output | 1 | Late sample-and-hold gate |
| seq_start | output | 1 | High during chip 0 of each sequence |

## Verification
The late gate and the wrap from slot 3 back to slot 0 only appear after 381 and 508 chips, which is over 1000 clocks of free running. The stimulus therefore lets the block run for more than two full dither cycles and compares every output on every clock against a model indexed by elapsed clocks. It then pulls reset in the middle of a cycle, away from any edge, and runs again from zero. This checks that the repetition state restarts and is not left at its old value.

// File: rtl/dsss_dither_pkg.sv
`timescale 1ns/1ps
package dsss_dither_pkg;
  // Slot of the dither cycle; the order is behaviour (two early, two late).
  typedef enum logic [1:0] {
    SLOT_E_SETTLE = 2'd0,
    SLOT_E_HOLD   = 2'd1,
    SLOT_L_SETTLE = 2'd2,
    SLOT_L_HOLD   = 2'd3
  } dith_slot_e;
endpackage

// File: rtl/chip_timer.sv
`timescale 1ns/1ps
module chip_timer #(
  parameter int unsigned SEQ_LEN = 127
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic                        chip_adv,
  output logic [$clog2(SEQ_LEN)-1:0]  chip_idx,
  output logic [1:0]                  slot
);
  localparam int unsigned IDX_W = $clog2(SEQ_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SEQ_LEN - 1);

  logic             phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [1:0]       slot_q, slot_d;

  always_comb begin
    phase_d = ~phase_q;
    idx_d   = idx_q;
    slot_d  = slot_q;
    if (phase_q) begin
      if (idx_q == IDX_LAST) begin
        idx_d  = '0;
        slot_d = slot_q + 2'd1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      idx_q   <= '0;
      slot_q  <= 2'd0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      slot_q  <= slot_d;
    end
  end

  assign chip_adv = phase_q;
  assign chip_idx = idx_q;
  assign slot     = slot_q;
endmodule

// File: rtl/pn_lfsr_gen.sv
`timescale 1ns/1ps
module pn_lfsr_gen #(
  parameter int unsigned     W     = 7,
  parameter int unsigned     TAP_A = 6,
  parameter int unsigned     TAP_B = 5,
  parameter logic [W-1:0]    SEED  = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  output logic chip
);
  logic [W-1:0] st_q, st_d;
  logic         fb;

  always_comb begin
    fb   = st_q[TAP_A] ^ st_q[TAP_B];
    st_d = st_q;
    if (step_en) st_d = {st_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign chip = st_q[W-1];
endmodule

// File: rtl/code_tap_line.sv
`timescale 1ns/1ps
module code_tap_line #(
  parameter int unsigned DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  output logic [DEPTH:0] taps
);
  logic [DEPTH:1] stg_q;

  assign taps[0] = din;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
    logic prev;
    if (g == 1) begin : g_first
      assign prev = din;
    end else begin : g_next
      assign prev = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= 1'b0;
      else        stg_q[g] <= prev;
    end
    assign taps[g] = stg_q[g];
  end
endmodule

// File: rtl/dith_sched.sv
`timescale 1ns/1ps
module dith_sched
  import dsss_dither_pkg::*;
(
  input  logic [1:0] slot,
  input  logic       early,
  input  logic       late,
  output logic       dith,
  output logic       gate_e,
  output logic       gate_l
);
  always_comb begin
    dith   = early;
    gate_e = 1'b0;
    gate_l = 1'b0;
    unique case (dith_slot_e'(slot))
      SLOT_E_SETTLE: dith = early;
      SLOT_E_HOLD:   begin dith = early; gate_e = 1'b1; end
      SLOT_L_SETTLE: dith = late;
      SLOT_L_HOLD:   begin dith = late;  gate_l = 1'b1; end
      default:       dith = early;
    endcase
  end
endmodule

// File: rtl/dsss_dither_codegen.sv
`timescale 1ns/1ps
module dsss_dither_codegen #(
  parameter int unsigned PN_W  = 7,
  parameter int unsigned TAP_A = 6,
  parameter int unsigned TAP_B = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic code_early,
  output logic code_punct,
  output logic code_late,
  output logic code_dith,
  output logic gate_early,
  output logic gate_late,
  output logic seq_start
);
  localparam int unsigned SEQ_LEN = (1 << PN_W) - 1;
  localparam int unsigned IDX_W   = $clog2(SEQ_LEN);
  localparam int unsigned SPREAD  = 2;  // half-chip stages from early to late

  logic             chip_adv;
  logic [IDX_W-1:0] chip_idx;
  logic [1:0]       slot;
  logic             pn_chip;
  logic [SPREAD:0]  taps;

  chip_timer #(.SEQ_LEN(SEQ_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .chip_adv(chip_adv),
    .chip_idx(chip_idx), .slot(slot)
  );

  pn_lfsr_gen #(.W(PN_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .SEED('1)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step_en(chip_adv), .chip(pn_chip)
  );

  code_tap_line #(.DEPTH(SPREAD)) u_taps (
    .clk(clk), .rst_n(rst_n), .din(pn_chip), .taps(taps)
  );

  assign code_early = taps[0];
  assign code_punct = taps[SPREAD/2];
  assign code_late  = taps[SPREAD];
  assign seq_start  = (chip_idx == '0);

  dith_sched u_sched (
    .slot(slot), .early(code_early), .late(code_late),
    .dith(code_dith), .gate_e(gate_early), .gate_l(gate_late)
  );
endmodule

// File: rtl/dsss_dither_chk.sv
`timescale 1ns/1ps
module dsss_dither_chk (
  input logic clk,
  input logic rst_n,
  input logic code_early,
  input logic code_punct,
  input logic code_late,
  input logic code_dith,
  input logic gate_early,
  input logic gate_late,
  input logic seq_start
);
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= 2'd0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  AST_GATES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_early && gate_late)); // R5
  AST_PUNCT_LAGS_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q != 2'd0) |-> (code_punct == $past(code_early))); // R3
  AST_LATE_LAGS_PUNCT: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (code_late == $past(code_punct))); // R3
  AST_DITH_EARLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gate_early |-> (code_dith == code_early)); // R4
  AST_DITH_LATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gate_late |-> (code_dith == code_late)); // R4
  AST_GATE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_early) || $rose(gate_late)) |-> seq_start); // R6
  AST_START_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_start) |=> seq_start); // R6
endmodule

bind dsss_dither_codegen dsss_dither_chk u_chk (.*);

// File: tb/tb_dsss_dither_codegen.sv
`timescale 1ns/1ps
module tb_dsss_dither_codegen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic code_early, code_punct, code_late, code_dith;
  logic gate_early, gate_late, seq_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit pn [0:126];
  int zrun = 0;

  always #4 clk = ~clk;

  dsss_dither_codegen dut (
    .clk(clk), .rst_n(rst_n),
    .code_early(code_early), .code_punct(code_punct), .code_late(code_late),
    .code_dith(code_dith), .gate_early(gate_early), .gate_late(gate_late),
    .seq_start(seq_start)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_early(input int t);
    return pn[(t / 2) % 127];
  endfunction

  task automatic check_reset_vals(input string tag);
    chk({tag, " R1 code_early"}, code_early, 1'b1);
    chk({tag, " R1 code_punct"}, code_punct, 1'b0);
    chk({tag, " R1 code_late"},  code_late,  1'b0);
    chk({tag, " R1 code_dith"},  code_dith,  1'b1);
    chk({tag, " R1 gate_early"}, gate_early, 1'b0);
    chk({tag, " R1 gate_late"},  gate_late,  1'b0);
    chk({tag, " R1 seq_start"},  seq_start,  1'b1);
  endtask

  // Compare all outputs against the model for clocks 0..ncyc-1 after release.
  task automatic run_model(input int ncyc, input string tag);
    zrun = 0;
    for (int t = 0; t < ncyc; t++) begin
      int  n  = t / 2;
      int  k  = (n / 127) % 4;
      bit  e  = m_early(t);
      bit  p  = (t >= 1) ? m_early(t - 1) : 1'b0;
      bit  l  = (t >= 2) ? m_early(t - 2) : 1'b0;
      string per = (t >= 1016) ? " R7" : "";
      chk({tag, " R2 early", per}, code_early, e);
      chk({tag, " R3 punct", per}, code_punct, p);
      chk({tag, " R3 late",  per}, code_late,  l);
      chk({tag, " R4 dith",  per}, code_dith,  (k < 2) ? e : l);
      chk({tag, " R5 gate_early", per}, gate_early, k == 1);
      chk({tag, " R5 gate_late",  per}, gate_late,  k == 3);
      chk({tag, " R6 seq_start",  per}, seq_start,  (n % 127) == 0);
      if ((t % 2) == 0) begin
        zrun = (code_early === 1'b0) ? zrun + 1 : 0;
        chk({tag, " R8 zero run <= 6"}, zrun <= 6, 1'b1);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 7; i++) pn[i] = 1'b1;
    for (int i = 0; i < 120; i++) pn[i + 7] = pn[i] ^ pn[i + 1];

    repeat (3) @(negedge clk);
    check_reset_vals("reset");
    rst_n = 1'b1;
    run_model(2200, "run1");

    // Mid-cycle asynchronous reset, away from a clock edge (R9).
    #1 rst_n = 1'b0;
    #1 check_reset_vals("R9 async");
    repeat (2) @(negedge clk);
    check_reset_vals("R9 held");
    rst_n = 1'b1;
    run_model(1200, "R9 run2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule